// File: doc/BRIEF.md
# Partitioned Weighted-Sum Accumulator

This block computes a signed matrix-vector weighted sum, `y[c] = sum over r of x[r] * W[r][c]`, for a square weight matrix of `DIM` rows by `DIM` columns. The matrix is cut into a `PARTS` x `PARTS` grid of equal tiles. Every tile keeps its own multi-bit weight elements. On each cycle, each tile reads one of its rows, multiplies that row by the input element for the row, and adds the products into its own accumulators. All tiles work at the same time.

Each tile has only `RD_UNITS` shared read lanes. Its columns are therefore swept in groups of `RD_UNITS`, one group after another. When a group's rows are complete, the partial sums from tiles in the same tile column are added together by a reduction tree. The tree has `log2(PARTS)` registered adder levels. One output beat leaves the tree for each column group. Weights are loaded one matrix row per cycle, and a mask picks which tile columns take the row in that same cycle. Input elements are loaded one per cycle. Both loads are held off while a weighted sum is running.

Top module: `pws_accel`

## Requirements
- R1: After reset, `ld_ready` is 1 and both `out_valid` and `done` are 0.
- R2: Each output lane carries the exact signed sum over all `DIM` rows of input times weight. Inputs and weights are 8-bit two's complement. The sum is exact even when every weight and every input is -128.
- R3: One run produces exactly `DIM/PARTS/RD_UNITS` beats. Beat k has `out_col` = k*`RD_UNITS`. Lane `p*RD_UNITS+u` of `out_sums`, taken as `ACC_W`-bit fields with lane 0 in the low bits, holds column `p*(DIM/PARTS) + k*RD_UNITS + u`.
- R4: `done` is high for exactly one cycle. It rises together with the last beat, `GROUPS*(DIM/PARTS) + log2(PARTS)` rising edges after the edge that accepts `start`.
- R5: A row write stores element c of `wr_data` (bits `[8c+7:8c]`) into `W[wr_row][c]`, but only for tile columns p whose bit `wr_mask[p]` is 1. Columns in tiles whose mask bit is 0 keep their old weights. Several tiles are written in the same cycle.
- R6: While a run is in progress, `ld_ready` is 0. Row writes and input loads presented in that time change neither the stored weights nor the inputs.
- R7: A `start` pulse during a run is ignored. It adds no beats and no second `done`.
- R8: `x_we` with `ld_ready` high stores `x_val` as input element `x_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_we | input | 1 | Input-element load strobe |
| x_idx | input | IW | Index of the input element to load |
| x_val | input | X_BITS | Signed input element value |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | IW | Matrix row to write |
| wr_mask | input | PARTS | Tile-column enable for the row write |
| wr_data | input | DIM*W_BITS | Row of signed weights, column c in bits [8c+7:8c] |
| ld_ready | output | 1 | High when loads and writes are accepted (no run active) |
| start | input | 1 | Begins a weighted-sum run when idle |
| done | output | 1 | One-cycle pulse with the final beat |
| out_valid | output | 1 | Output beat valid |
| out_col | output | RW | Column offset of this beat inside each tile |
| out_sums | output | LANES*ACC_W | Signed sums, one field per lane |

## Verification
On every cycle, the embedded assertions check four things. Output beats appear only inside a run. A tile takes a write only while idle. A run always begins from row 0 of group 0. The run ends only after the final tree level has delivered `done`. The bench scenarios cover the rest. These are the arithmetic of the sums (including the all -128 extreme), the lane-to-column mapping, and the exact latency. They also show that masked tiles keep their weights and that writes, loads and restarts pushed during a run leave no trace in the results, both in that run and in the next one.

// File: rtl/pws_pkg.sv
package pws_pkg;

  // width of an index able to address n items, never below one bit
  function automatic int ubits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // one multiply-accumulate step on generously wide signed operands
  function automatic logic signed [47:0] mac(input logic signed [47:0] acc,
                                             input logic signed [23:0] w,
                                             input logic signed [23:0] x);
    return acc + 48'(w * x);
  endfunction

endpackage

// File: rtl/pws_seq.sv
module pws_seq #(
  parameter int S      = 8,
  parameter int GROUPS = 2,
  localparam int RW    = pws_pkg::ubits(S),
  localparam int GW    = pws_pkg::ubits(GROUPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          done_i,
  output logic          busy,
  output logic [RW-1:0] row,
  output logic [GW-1:0] grp,
  output logic          acc_en,
  output logic          acc_clr,
  output logic          fin,
  output logic          fin_last
);
  logic iss;
  logic row_end, grp_end;

  assign row_end  = (row == RW'(S - 1));
  assign grp_end  = (grp == GW'(GROUPS - 1));
  assign acc_en   = iss;
  assign acc_clr  = (row == '0);
  assign fin      = iss && row_end;
  assign fin_last = fin && grp_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      iss  <= 1'b0;
      row  <= '0;
      grp  <= '0;
    end else if (!busy && start) begin
      busy <= 1'b1;
      iss  <= 1'b1;
      row  <= '0;
      grp  <= '0;
    end else begin
      if (done_i) busy <= 1'b0;
      if (iss) begin
        if (row_end) begin
          row <= '0;
          if (grp_end) iss <= 1'b0;
          else         grp <= grp + 1'b1;
        end else begin
          row <= row + 1'b1;
        end
      end
    end
  end

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done_i));

  // R4
  done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> busy);

  // R3
  run_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (row == '0 && grp == '0 && iss));

endmodule

// File: rtl/pws_subarray.sv
module pws_subarray #(
  parameter int S      = 8,
  parameter int RD     = 4,
  parameter int W_BITS = 8,
  parameter int X_BITS = 8,
  parameter int ACC_W  = 21,
  localparam int RW    = pws_pkg::ubits(S),
  localparam int GW    = pws_pkg::ubits(S / RD)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy_i,
  input  logic                     wr_go,
  input  logic [RW-1:0]            wr_row,
  input  logic [S*W_BITS-1:0]      wr_data,
  input  logic [RW-1:0]            rd_row,
  input  logic [GW-1:0]            rd_grp,
  input  logic signed [X_BITS-1:0] x_cur,
  input  logic                     acc_en,
  input  logic                     acc_clr,
  output logic [RD*ACC_W-1:0]      acc_flat
);
  logic signed [W_BITS-1:0] mem [S][S];

  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int c = 0; c < S; c++) mem[wr_row][c] <= wr_data[c*W_BITS +: W_BITS];
    end
  end

  for (genvar u = 0; u < RD; u++) begin : lane
    logic signed [W_BITS-1:0] wsel;
    logic signed [ACC_W-1:0]  acc;
    logic signed [47:0]       base;

    always_comb wsel = mem[rd_row][RW'(int'(rd_grp) * RD + u)];
    assign base = acc_clr ? 48'sd0 : 48'(acc);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc <= '0;
      else if (acc_en) acc <= ACC_W'(pws_pkg::mac(base, 24'(wsel), 24'(x_cur)));
    end

    assign acc_flat[u*ACC_W +: ACC_W] = acc;
  end

  // R6
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !busy_i);

endmodule

// File: rtl/pws_reduce.sv
module pws_reduce #(
  parameter int PARTS = 4,
  parameter int LANES = 16,
  parameter int ACC_W = 21,
  parameter int TW    = 2,
  localparam int L    = $clog2(PARTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_vld,
  input  logic [TW-1:0]              in_tag,
  input  logic [PARTS*LANES*ACC_W-1:0] in_flat,
  output logic                       out_vld,
  output logic [TW-1:0]              out_tag,
  output logic [LANES*ACC_W-1:0]     out_flat
);
  for (genvar k = 0; k <= L; k++) begin : lv
    localparam int CNT = PARTS >> k;
    logic signed [ACC_W-1:0] s [CNT][LANES];
    logic                    v;
    logic [TW-1:0]           tag;

    if (k == 0) begin : leaf
      always_comb begin
        for (int j = 0; j < CNT; j++)
          for (int l = 0; l < LANES; l++)
            s[j][l] = in_flat[(j*LANES + l)*ACC_W +: ACC_W];
      end
      assign v   = in_vld;
      assign tag = in_tag;
    end else begin : stage
      always_ff @(posedge clk) begin
        for (int j = 0; j < CNT; j++)
          for (int l = 0; l < LANES; l++)
            s[j][l] <= lv[k-1].s[2*j][l] + lv[k-1].s[2*j+1][l];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v   <= 1'b0;
          tag <= '0;
        end else begin
          v   <= lv[k-1].v;
          tag <= lv[k-1].tag;
        end
      end
    end
  end

  assign out_vld = lv[L].v;
  assign out_tag = lv[L].tag;
  for (genvar l = 0; l < LANES; l++) begin : pack
    assign out_flat[l*ACC_W +: ACC_W] = lv[L].s[0][l];
  end

endmodule

// File: rtl/pws_accel.sv
module pws_accel #(
  parameter int DIM      = 32,
  parameter int PARTS    = 4,
  parameter int RD_UNITS = 4,
  parameter int W_BITS   = 8,
  parameter int X_BITS   = 8,
  localparam int S       = DIM / PARTS,
  localparam int RW      = pws_pkg::ubits(S),
  localparam int GROUPS  = S / RD_UNITS,
  localparam int GW      = pws_pkg::ubits(GROUPS),
  localparam int LANES   = PARTS * RD_UNITS,
  localparam int IW      = pws_pkg::ubits(DIM),
  localparam int ACC_W   = W_BITS + X_BITS + $clog2(DIM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    x_we,
  input  logic [IW-1:0]           x_idx,
  input  logic [X_BITS-1:0]       x_val,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_row,
  input  logic [PARTS-1:0]        wr_mask,
  input  logic [DIM*W_BITS-1:0]   wr_data,
  output logic                    ld_ready,
  input  logic                    start,
  output logic                    done,
  output logic                    out_valid,
  output logic [RW-1:0]           out_col,
  output logic [LANES*ACC_W-1:0]  out_sums
);
  localparam int TW = GW + 1;

  logic          busy, acc_en, acc_clr, fin, fin_last;
  logic [RW-1:0] row;
  logic [GW-1:0] grp;
  logic          fin_q;
  logic [TW-1:0] tag_q, out_tag;
  logic signed [X_BITS-1:0] xv [DIM];
  logic signed [X_BITS-1:0] xsel [PARTS];
  wire  [PARTS*LANES*ACC_W-1:0] leaf_flat;

  assign ld_ready = !busy;

  // input vector register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DIM; i++) xv[i] <= '0;
    end else if (x_we && ld_ready) begin
      xv[x_idx] <= x_val;
    end
  end

  pws_seq #(.S(S), .GROUPS(GROUPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .done_i(done),
    .busy(busy), .row(row), .grp(grp), .acc_en(acc_en),
    .acc_clr(acc_clr), .fin(fin), .fin_last(fin_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q <= 1'b0;
      tag_q <= '0;
    end else begin
      fin_q <= fin;
      tag_q <= {fin_last, grp};
    end
  end

  for (genvar pr = 0; pr < PARTS; pr++) begin : trow
    always_comb xsel[pr] = xv[IW'(pr * S + int'(row))];
    for (genvar pc = 0; pc < PARTS; pc++) begin : tcol
      logic go;
      assign go = wr_en && ld_ready && wr_mask[pc] && ((int'(wr_row) / S) == pr);
      pws_subarray #(
        .S(S), .RD(RD_UNITS), .W_BITS(W_BITS), .X_BITS(X_BITS), .ACC_W(ACC_W)
      ) u_tile (
        .clk(clk), .rst_n(rst_n), .busy_i(busy), .wr_go(go),
        .wr_row(wr_row[RW-1:0]),
        .wr_data(wr_data[pc*S*W_BITS +: S*W_BITS]),
        .rd_row(row), .rd_grp(grp), .x_cur(xsel[pr]),
        .acc_en(acc_en), .acc_clr(acc_clr),
        .acc_flat(leaf_flat[(pr*LANES + pc*RD_UNITS)*ACC_W +: RD_UNITS*ACC_W])
      );
    end
  end

  pws_reduce #(.PARTS(PARTS), .LANES(LANES), .ACC_W(ACC_W), .TW(TW)) u_tree (
    .clk(clk), .rst_n(rst_n), .in_vld(fin_q), .in_tag(tag_q),
    .in_flat(leaf_flat), .out_vld(out_valid), .out_tag(out_tag),
    .out_flat(out_sums)
  );

  assign out_col = RW'(int'(out_tag[GW-1:0]) * RD_UNITS);
  assign done    = out_valid && out_tag[TW-1];

  // R3
  beat_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

endmodule

// File: tb/tb_pws_accel.sv
module tb_pws_accel;
  localparam int DIM = 8, PARTS = 2, RD = 2, WB = 8, XB = 8;
  localparam int S = DIM / PARTS, GROUPS = S / RD, L = 1, LANES = PARTS * RD;
  localparam int ACC_W = WB + XB + 3, IW = 3, RW = 2;
  localparam int LAT = GROUPS * S + L;

  logic clk = 1'b0, rst_n = 1'b0;
  logic x_we = 0, wr_en = 0, start = 0;
  logic [IW-1:0] x_idx = '0, wr_row = '0;
  logic [XB-1:0] x_val = '0;
  logic [PARTS-1:0] wr_mask = '0;
  logic [DIM*WB-1:0] wr_data = '0;
  logic ld_ready, done, out_valid;
  logic [RW-1:0] out_col;
  logic [LANES*ACC_W-1:0] out_sums;

  int wm [DIM][DIM];
  int xm [DIM];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  pws_accel #(.DIM(DIM), .PARTS(PARTS), .RD_UNITS(RD), .W_BITS(WB), .X_BITS(XB)) dut (
    .clk(clk), .rst_n(rst_n), .x_we(x_we), .x_idx(x_idx), .x_val(x_val),
    .wr_en(wr_en), .wr_row(wr_row), .wr_mask(wr_mask), .wr_data(wr_data),
    .ld_ready(ld_ready), .start(start), .done(done), .out_valid(out_valid),
    .out_col(out_col), .out_sums(out_sums)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gv(input int seed, input int a, input int b);
    if (seed == -1) return -128;
    if (seed == -2) return 127;
    return ((a * 29 + b * 13 + seed * 71 + a * b * 5) % 256) - 128;
  endfunction

  // R8: load every input element
  task automatic load_x(input int seed);
    for (int i = 0; i < DIM; i++) begin
      @(negedge clk);
      x_we = 1; x_idx = IW'(i);
      xm[i] = (seed == -2) ? -128 : gv(seed, i, 3);
      x_val = XB'(xm[i]);
    end
    @(negedge clk);
    x_we = 0;
  endtask

  // R5: write one row into the tile columns enabled by mask
  task automatic write_row(input int r, input logic [PARTS-1:0] mask, input int seed);
    @(negedge clk);
    wr_en = 1; wr_row = IW'(r); wr_mask = mask;
    for (int c = 0; c < DIM; c++) begin
      wr_data[c*WB +: WB] = WB'(gv(seed, r, c));
      if (mask[c / S]) wm[r][c] = gv(seed, r, c);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input bit poke);
    int beats;
    bit seen;
    beats = 0; seen = 0;
    @(negedge clk);
    start = 1;
    @(posedge clk);
    for (int cyc = 1; cyc <= 40 && !seen; cyc++) begin
      @(negedge clk);
      if (poke && cyc >= 2 && cyc <= 4) begin
        // R6 R7: loads, writes and start during a run
        wr_en = 1; wr_row = '0; wr_mask = '1; wr_data = {DIM{8'h07}};
        x_we = 1; x_idx = '0; x_val = 8'd99; start = 1;
        chk(ld_ready == 1'b0, "R6 ld_ready in run", ld_ready, 0);
      end else begin
        wr_en = 0; x_we = 0; start = 0;
      end
      @(posedge clk);
      #1;
      if (out_valid) begin
        chk(int'(out_col) == beats * RD, "R3 out_col", out_col, beats * RD);
        for (int l = 0; l < LANES; l++) begin
          longint act, exp;
          int col;
          col = (l / RD) * S + beats * RD + (l % RD);
          exp = 0;
          for (int r = 0; r < DIM; r++) exp += longint'(xm[r]) * wm[r][col];
          act = $signed(out_sums[l*ACC_W +: ACC_W]);
          chk(act == exp, "R2 lane sum", act, exp);
        end
        beats++;
      end
      if (done) begin
        seen = 1;
        chk(cyc == LAT, "R4 done latency", cyc, LAT);
      end
    end
    chk(seen, "R4 done seen", seen, 1);
    chk(beats == GROUPS, "R3 R7 beat count", beats, GROUPS);
    @(negedge clk);
    wr_en = 0; x_we = 0; start = 0;
    @(posedge clk); #1;
    chk(done == 1'b0 && out_valid == 1'b0, "R4 R7 no extra beat", done, 0);
    @(posedge clk); #1;
    chk(ld_ready == 1'b1, "R6 ready after run", ld_ready, 1);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL R4 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(ld_ready == 1'b1, "R1 ld_ready", ld_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    @(negedge clk);
    rst_n = 1;
    // R2 sweep over several patterns, including both extremes
    for (int seed = -2; seed < 5; seed++) begin
      load_x(seed);
      for (int r = 0; r < DIM; r++) write_row(r, '1, seed);
      run(0);
    end
    // R5: masked writes touch only the selected tile columns
    write_row(5, 2'b01, 9);
    write_row(1, 2'b10, 11);
    write_row(6, 2'b11, 13);
    run(0);
    // R6 R7: stimulus pushed during a run leaves no trace now or later
    run(1);
    run(0);
    // R8: single element reload
    @(negedge clk);
    x_we = 1; x_idx = 3'd6; x_val = 8'hF3; xm[6] = -13;
    @(negedge clk);
    x_we = 0;
    run(0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule